// File: doc/BRIEF.md
# Raster Sync Waveform Generator

This block turns the current raster position into a small set of sync and control lines. It works in three stages. First, a bank of identical pulse generators each watches for two programmed points in the signed (x, y) coordinate space. A match on the set point drives that generator's level high. A match on the clear point drives it low. Second, each output has its own combiner that picks two generator levels and merges them with a logic function. Third, each output can be shifted half a pixel clock later by a stage clocked on the falling edge.

The coordinate source supplies x, y and a field bit on every pixel clock, in two's complement. Coordinates may be negative, so blanking regions can sit before the visible origin. Any generator can be limited to one field. Interlaced timing can then place edges in one field only. All programmable settings arrive as static input buses. The register file that holds them sits outside this block.

Each generator is a two-state machine with the states PULSE_LOW and PULSE_HIGH. It has four transitions:
- **set-match** goes from PULSE_LOW to PULSE_HIGH.
- **clear-match** goes from PULSE_HIGH to PULSE_LOW.
- **clear-priority** keeps PULSE_LOW when both points match at once.
- **reset** returns to PULSE_LOW from either state.

Top module: `raster_sync_array`

## Requirements
- R1: A synchronous active-high `rst` puts every generator in PULSE_LOW and clears every falling-edge capture register. After reset, with no inversion selected, every `sync_out` bit reads 0.
- R2: When (`pos_x`, `pos_y`) equals a generator's set point (and its field qualifier passes), that generator's level is high from the next rising clock edge.
- R3: When the position equals a generator's clear point (and its field qualifier passes), that generator's level is low from the next rising clock edge.
- R4: When a generator's set point and clear point both match in the same cycle, the clear wins and the level is low after the edge.
- R5: A position that matches neither point leaves the level unchanged. This includes a position where only x or only y agrees.
- R6: Coordinates are CW-bit two's complement, and negative positions match exactly, for example -3 is 12'hFFD.
- R7: Generator g has a qualifier bit `gen_fq_en[g]` and a required field value `gen_fq_val[g]`. When the qualifier bit is 1, set and clear matches count only when `field_bit` equals `gen_fq_val[g]`. When it is 0, the field is ignored.
- R8: Output o has two operand selects and an operation:
  - `cmb_sel_a`/`cmb_sel_b` slice o (SEL_W bits each) choose generator levels; a select of NUM_GEN or above reads 0.
  - `cmb_op` slice o (2 bits) picks the operation: 0 = AND, 1 = OR, 2 = XOR, 3 = operand A alone.
  - `cmb_inv[o]` = 1 inverts the result.
- R9: With `half_en[o]` = 1, `sync_out[o]` shows the combiner value captured at the most recent falling clock edge, so it trails by half a pixel clock. With `half_en[o]` = 0 it follows the combiner directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_x | input | CW | Current horizontal coordinate, two's complement |
| pos_y | input | CW | Current vertical coordinate, two's complement |
| field_bit | input | 1 | Current field of the frame pair |
| gen_set_x | input | NUM_GEN*CW | Set-point x per generator, slice g for generator g |
| gen_set_y | input | NUM_GEN*CW | Set-point y per generator |
| gen_clr_x | input | NUM_GEN*CW | Clear-point x per generator |
| gen_clr_y | input | NUM_GEN*CW | Clear-point y per generator |
| gen_fq_en | input | NUM_GEN | Field qualifier enable per generator |
| gen_fq_val | input | NUM_GEN | Required field value per generator |
| cmb_sel_a | input | NUM_OUT*SEL_W | Operand A generator index per output |
| cmb_sel_b | input | NUM_OUT*SEL_W | Operand B generator index per output |
| cmb_op | input | NUM_OUT*2 | Combine operation per output |
| cmb_inv | input | NUM_OUT | Invert combined result per output |
| half_en | input | NUM_OUT | Half-clock delay enable per output |
| sync_out | output | NUM_OUT | Generated sync lines |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the set and clear transitions of one generator. The bench provokes it by programming one generator with identical set and clear points and walking the raster across that point. A scoreboard then expects the level to stay low.

The second pair is a generator edge and the half-clock stage. Every expected item is compared twice within one cycle: before the falling edge, a delayed output must still show the previous combiner value; after it, the delayed output must show the new value. This also covers cycles where a delay enable or a combine setting changes together with a generator transition.

// File: rtl/sync_pkg.sv
package sync_pkg;

    // Combine operation encoding for each output
    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_XOR  = 2'd2,
        OP_PASS = 2'd3
    } comb_op_e;

    // RS flip-flop state of a pulse generator
    typedef enum logic {
        PULSE_LOW  = 1'b0,
        PULSE_HIGH = 1'b1
    } pulse_state_e;

endpackage

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [CW-1:0] pos_x,
    input  logic signed [CW-1:0] pos_y,
    input  logic                 field_bit,
    input  logic signed [CW-1:0] set_x,
    input  logic signed [CW-1:0] set_y,
    input  logic signed [CW-1:0] clr_x,
    input  logic signed [CW-1:0] clr_y,
    input  logic                 fq_en,
    input  logic                 fq_val,
    output logic                 level
);

    pulse_state_e state, state_nxt;
    logic         field_ok;
    logic         set_hit;
    logic         clr_hit;

    assign field_ok = !fq_en || (field_bit == fq_val);
    assign set_hit  = field_ok && (pos_x == set_x) && (pos_y == set_y);
    assign clr_hit  = field_ok && (pos_x == clr_x) && (pos_y == clr_y);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= PULSE_LOW;
        else     state <= state_nxt;
    end

    // Transitions: set-match, clear-match, clear-priority
    always_comb begin
        state_nxt = state;
        unique case (state)
            PULSE_LOW: begin
                if (set_hit && !clr_hit) state_nxt = PULSE_HIGH;
            end
            PULSE_HIGH: begin
                if (clr_hit) state_nxt = PULSE_LOW;
            end
        endcase
    end

    // Output process
    always_comb begin
        level = (state == PULSE_HIGH);
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !level);

    // R2
    set_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hit && !clr_hit) |=> level);

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> !level);

    // R5
    hold_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_hit && !clr_hit) |=> $stable(level));

endmodule

// File: rtl/sync_combiner.sv
module sync_combiner
    import sync_pkg::*;
#(
    parameter int NUM_GEN = 6,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_GEN-1:0] levels,
    input  logic [SEL_W-1:0]   sel_a,
    input  logic [SEL_W-1:0]   sel_b,
    input  comb_op_e           op,
    input  logic               inv,
    output logic               y
);

    localparam int PAD_N = 2 ** SEL_W;

    logic [PAD_N-1:0] lv_pad;
    logic             opa;
    logic             opb;
    logic             raw;

    always_comb begin
        lv_pad                = '0;
        lv_pad[NUM_GEN-1:0]   = levels;
        opa                   = lv_pad[sel_a];
        opb                   = lv_pad[sel_b];
        unique case (op)
            OP_AND:  raw = opa & opb;
            OP_OR:   raw = opa | opb;
            OP_XOR:  raw = opa ^ opb;
            OP_PASS: raw = opa;
        endcase
        y = raw ^ inv;
    end

endmodule

// File: rtl/sync_half_delay.sv
module sync_half_delay (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic en,
    output logic q
);

    logic cap;

    always_ff @(negedge clk) begin
        if (rst) cap <= 1'b0;
        else     cap <= d;
    end

    assign q = en ? cap : d;

    // R9
    half_lag_chk: assert property (@(negedge clk) disable iff (rst)
        (en && !$past(rst)) |-> (q == $past(d)));

endmodule

// File: rtl/raster_sync_array.sv
module raster_sync_array
    import sync_pkg::*;
#(
    parameter  int CW      = 12,
    parameter  int NUM_GEN = 6,
    parameter  int NUM_OUT = 4,
    localparam int SEL_W   = $clog2(NUM_GEN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [CW-1:0]       pos_x,
    input  logic signed [CW-1:0]       pos_y,
    input  logic                       field_bit,
    input  logic [NUM_GEN*CW-1:0]      gen_set_x,
    input  logic [NUM_GEN*CW-1:0]      gen_set_y,
    input  logic [NUM_GEN*CW-1:0]      gen_clr_x,
    input  logic [NUM_GEN*CW-1:0]      gen_clr_y,
    input  logic [NUM_GEN-1:0]         gen_fq_en,
    input  logic [NUM_GEN-1:0]         gen_fq_val,
    input  logic [NUM_OUT*SEL_W-1:0]   cmb_sel_a,
    input  logic [NUM_OUT*SEL_W-1:0]   cmb_sel_b,
    input  logic [NUM_OUT*2-1:0]       cmb_op,
    input  logic [NUM_OUT-1:0]         cmb_inv,
    input  logic [NUM_OUT-1:0]         half_en,
    output logic [NUM_OUT-1:0]         sync_out
);

    logic [NUM_GEN-1:0] gen_level;
    logic [NUM_OUT-1:0] comb_level;

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_pulse
            sync_pulse_gen #(.CW(CW)) u_pg (
                .clk       (clk),
                .rst       (rst),
                .pos_x     (pos_x),
                .pos_y     (pos_y),
                .field_bit (field_bit),
                .set_x     (gen_set_x[g*CW +: CW]),
                .set_y     (gen_set_y[g*CW +: CW]),
                .clr_x     (gen_clr_x[g*CW +: CW]),
                .clr_y     (gen_clr_y[g*CW +: CW]),
                .fq_en     (gen_fq_en[g]),
                .fq_val    (gen_fq_val[g]),
                .level     (gen_level[g])
            );
        end

        for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
            sync_combiner #(.NUM_GEN(NUM_GEN), .SEL_W(SEL_W)) u_cmb (
                .levels (gen_level),
                .sel_a  (cmb_sel_a[o*SEL_W +: SEL_W]),
                .sel_b  (cmb_sel_b[o*SEL_W +: SEL_W]),
                .op     (comb_op_e'(cmb_op[o*2 +: 2])),
                .inv    (cmb_inv[o]),
                .y      (comb_level[o])
            );

            sync_half_delay u_hd (
                .clk (clk),
                .rst (rst),
                .d   (comb_level[o]),
                .en  (half_en[o]),
                .q   (sync_out[o])
            );
        end
    endgenerate

endmodule

// File: tb/raster_sync_array_bench.sv
module raster_sync_array_bench;

    localparam int CW = 12;
    localparam int NG = 6;
    localparam int NO = 4;
    localparam int SW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst;
    logic signed [CW-1:0] pos_x, pos_y;
    logic                 field_bit;
    logic [NG*CW-1:0]     gen_set_x, gen_set_y, gen_clr_x, gen_clr_y;
    logic [NG-1:0]        fq_en, fq_val;
    logic [NO*SW-1:0]     cmb_sel_a, cmb_sel_b;
    logic [NO*2-1:0]      cmb_op;
    logic [NO-1:0]        inv, hen;
    logic [NO-1:0]        sync_out;

    int cfg_sx[NG], cfg_sy[NG], cfg_cx[NG], cfg_cy[NG];
    int sel_a[NO], sel_b[NO], op[NO];

    always_comb begin
        for (int i = 0; i < NG; i++) begin
            gen_set_x[i*CW +: CW] = cfg_sx[i][CW-1:0];
            gen_set_y[i*CW +: CW] = cfg_sy[i][CW-1:0];
            gen_clr_x[i*CW +: CW] = cfg_cx[i][CW-1:0];
            gen_clr_y[i*CW +: CW] = cfg_cy[i][CW-1:0];
        end
        for (int o = 0; o < NO; o++) begin
            cmb_sel_a[o*SW +: SW] = sel_a[o][SW-1:0];
            cmb_sel_b[o*SW +: SW] = sel_b[o][SW-1:0];
            cmb_op[o*2 +: 2]      = op[o][1:0];
        end
    end

    raster_sync_array #(.CW(CW), .NUM_GEN(NG), .NUM_OUT(NO)) u_raster_sync_array (
        .clk(clk), .rst(rst), .pos_x(pos_x), .pos_y(pos_y), .field_bit(field_bit),
        .gen_set_x(gen_set_x), .gen_set_y(gen_set_y),
        .gen_clr_x(gen_clr_x), .gen_clr_y(gen_clr_y),
        .gen_fq_en(fq_en), .gen_fq_val(fq_val),
        .cmb_sel_a(cmb_sel_a), .cmb_sel_b(cmb_sel_b), .cmb_op(cmb_op),
        .cmb_inv(inv), .half_en(hen), .sync_out(sync_out)
    );

    typedef struct {
        int            due;
        logic [NO-1:0] early;
        logic [NO-1:0] late;
        string         tag;
    } item_t;

    item_t         sb[$];
    int            cyc = 0;
    int            checks = 0;
    int            fails = 0;
    logic [NG-1:0] mstate = '0;
    logic [NO-1:0] mcap = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NO-1:0] comb_of(input logic [NG-1:0] st);
        logic [NO-1:0] res;
        logic a, b, r;
        for (int o = 0; o < NO; o++) begin
            a = (sel_a[o] < NG) ? st[sel_a[o]] : 1'b0;
            b = (sel_b[o] < NG) ? st[sel_b[o]] : 1'b0;
            case (op[o])
                0:       r = a & b;
                1:       r = a | b;
                2:       r = a ^ b;
                default: r = a;
            endcase
            res[o] = r ^ inv[o];
        end
        return res;
    endfunction

    function automatic bit hit(int i, int px, int py, int x, int y, logic f);
        return (x == px) && (y == py) && (!fq_en[i] || (f == fq_val[i]));
    endfunction

    task automatic chk(logic [NO-1:0] got, logic [NO-1:0] exp, string tag, string phase);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s (%s): got %b expected %b", tag, phase, got, exp);
        end
    endtask

    // Driver: applies one position in the window after the falling edge,
    // predicts the outputs and queues them for the monitor.
    task automatic step(int x, int y, logic f, logic r, string tag);
        item_t         it;
        logic [NG-1:0] nxt;
        logic [NO-1:0] cnew, capn;
        pos_x     = x[CW-1:0];
        pos_y     = y[CW-1:0];
        field_bit = f;
        rst       = r;
        nxt = mstate;
        for (int i = 0; i < NG; i++) begin
            if (r) nxt[i] = 1'b0;
            else if (hit(i, cfg_cx[i], cfg_cy[i], x, y, f)) nxt[i] = 1'b0;
            else if (hit(i, cfg_sx[i], cfg_sy[i], x, y, f)) nxt[i] = 1'b1;
        end
        cnew = comb_of(nxt);
        capn = r ? '0 : cnew;
        for (int o = 0; o < NO; o++) begin
            it.early[o] = hen[o] ? mcap[o] : cnew[o];
            it.late[o]  = hen[o] ? capn[o] : cnew[o];
        end
        it.due = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
        mstate = nxt;
        mcap   = capn;
        @(posedge clk);
        #8;
    endtask

    // Monitor: compares before and after the falling edge of the due cycle
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0 && sb[0].due == cyc) begin
                chk(sync_out, sb[0].early, sb[0].tag, "before falling edge");
                #4;
                chk(sync_out, sb[0].late, sb[0].tag, "after falling edge");
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; pos_x = '0; pos_y = '0; field_bit = 1'b0;
        fq_en = '0; fq_val = '0; inv = '0; hen = '0;
        cfg_sx = '{2, 4, -3, 6, 3, 1};   cfg_sy = '{0, 0, -1, 1, 2, 3};
        cfg_cx = '{5, 8, -1, 9, 3, 2};   cfg_cy = '{0, 0, -1, 1, 2, 3};
        fq_en[5] = 1'b1; fq_val[5] = 1'b1;
        sel_a = '{0, 2, 4, 0}; sel_b = '{1, 3, 5, 1}; op = '{0, 1, 2, 2};
        repeat (3) @(posedge clk);
        #8;

        // R1: outputs low straight after reset, no inversion yet
        step(100, 100, 1'b0, 1'b0, "R1 reset state");
        inv[1] = 1'b1; hen[2] = 1'b1; hen[3] = 1'b1;
        step(100, 100, 1'b0, 1'b0, "R8 inversion on idle levels");

        // R2 R3: walk line 0
        for (int x = 0; x < 10; x++) step(x, 0, 1'b0, 1'b0, "R2 R3 line walk");

        // R5: partial matches leave levels alone
        step(2, 0, 1'b0, 1'b0, "R2 set gen0");
        step(2, 1, 1'b0, 1'b0, "R5 y miss");
        step(5, 7, 1'b0, 1'b0, "R5 clear x only");
        step(7, 0, 1'b0, 1'b0, "R5 no match");

        // R6: negative coordinates
        for (int x = -4; x <= 0; x++) step(x, -1, 1'b0, 1'b0, "R6 negative line");

        // gen3 through OR-with-invert output
        for (int x = 5; x <= 10; x++) step(x, 1, 1'b1, 1'b0, "R2 R3 gen3 line");

        // R4: set and clear on the same point
        step(3, 2, 1'b0, 1'b0, "R4 clear wins");
        step(3, 2, 1'b1, 1'b0, "R4 clear wins again");

        // R7: field qualified generator 5
        step(1, 3, 1'b0, 1'b0, "R7 wrong field set ignored");
        step(1, 3, 1'b1, 1'b0, "R7 right field set");
        step(2, 3, 1'b0, 1'b0, "R7 wrong field clear ignored");
        step(2, 3, 1'b1, 1'b0, "R7 right field clear");
        fq_en[5] = 1'b0;
        step(1, 3, 1'b0, 1'b0, "R7 qualifier off");

        // R8: sweep combine ops with gen0 high, gen1 low, then both high
        step(2, 0, 1'b0, 1'b0, "R8 prepare");
        for (int k = 0; k < 8; k++) begin
            op[0] = k % 4; inv[0] = k[2];
            step(50, 50, 1'b0, 1'b0, "R8 op sweep");
        end
        step(4, 0, 1'b0, 1'b0, "R8 both high");
        for (int k = 0; k < 4; k++) begin
            op[0] = k;
            step(50, 50, 1'b0, 1'b0, "R8 op sweep both");
        end
        sel_a[0] = 7; op[0] = 3; inv[0] = 1'b0;
        step(50, 50, 1'b0, 1'b0, "R8 select out of range");
        sel_a[0] = 0; op[0] = 3;

        // R9: half-clock delay on output 0
        hen[0] = 1'b1;
        step(5, 0, 1'b0, 1'b0, "R9 delayed fall");
        step(2, 0, 1'b0, 1'b0, "R9 delayed rise");
        step(50, 50, 1'b0, 1'b0, "R9 steady");
        hen[0] = 1'b0;
        step(5, 0, 1'b0, 1'b0, "R9 direct fall");

        // R1: reset in mid-run
        step(2, 0, 1'b0, 1'b0, "R1 prepare");
        step(4, 0, 1'b0, 1'b0, "R1 prepare second");
        step(50, 50, 1'b0, 1'b1, "R1 mid-run reset");
        step(50, 50, 1'b0, 1'b0, "R1 after reset");

        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule